// File: doc/BRIEF.md
# Per-Pin Interrupt Sense Controller

This block watches the effective input value of an 8-bit port and sets a per-pin event flag when that pin meets the condition chosen in its own control byte. Each pin has its own sense selector. A pin can be off, or it can react to any change, to a rising change, to a falling change, or to a held low level. There is no global enable. A pin whose selector is not off takes part at once.

Events are ORed into a flag register. Software clears flags by writing ones with a clear strobe. One port interrupt request is high while any flag is set. The input vector is taken as already synchronised. It is the value the port reads back, so a pin driven as an output can flag its own changes. Address decode is outside the block: the clear port is a plain strobe and mask.

Top module: `pin_irq_sense`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, `flags` is 0 and `irq` is 0.
- R2: Pin i's sense code is bits [2:0] of control byte i, which is `pin_ctrl[8*i+7:8*i]`. Code 0 (off) never sets flag i.
- R3: Code 1 (any change) sets flag i when `pin_level[i]` differs from its value at the previous clock edge. The flag reads 1 after the edge at which the new value is sampled.
- R4: Code 2 (rising) sets flag i only when the pin was 0 at the previous edge and is 1 now.
- R5: Code 3 (falling) sets flag i only when the pin was 1 at the previous edge and is 0 now.
- R6: Code 5 (low level) sets flag i at every edge where the pin is 0. Clearing the flag while the pin stays low has no lasting effect.
- R7: Codes 4, 6 and 7 behave as off, and control bits [7:3] have no effect.
- R8: New events are ORed into `flags`, several pins may flag at the same edge, and flags already set stay set.
- R9: At an edge with `clr_valid` high, flags whose `clr_mask` bit is 1 are cleared, and other flags are kept. With `clr_valid` low, `clr_mask` has no effect.
- R10: If a clear and a new event hit the same bit at the same edge, the flag ends up set.
- R11: `irq` is high exactly when any flag is set, and it falls only after every flag has been cleared.
- R12: At the first edge after reset is released, no edge mode (codes 1, 2, 3) flags. That edge only records the input as the previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_level | input | 8 | Effective port input value |
| pin_ctrl | input | 64 | Eight control bytes, byte i at bits [8*i+7:8*i] |
| clr_valid | input | 1 | Flag-clear write strobe |
| clr_mask | input | 8 | Ones select the flags to clear |
| flags | output | 8 | Event flag register |
| irq | output | 1 | Port interrupt request |

## Verification
The bench targets these cases:
- A clear and an event on the same bit at the same edge. A design that gives priority to the clear loses the event.
- Clearing a pin that is held low in level mode. A design that treats level mode as an edge would leave the flag at 0.
- The first edge after reset, with the inputs already high. A design with a zeroed history would report false rising edges.
- Reserved codes, and control bytes with the upper bits set. A design that decodes these as real modes produces stray flags.
- Dropping `irq` while some flags are still set.

// File: rtl/pin_sense_pkg.sv
package pin_sense_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        SENSE_OFF  = 3'd0,
        SENSE_BOTH = 3'd1,
        SENSE_RISE = 3'd2,
        SENSE_FALL = 3'd3,
        SENSE_LOW  = 3'd5
    } sense_mode_e;

    typedef struct packed {
        logic cur;
        logic prev;
        logic armed;
    } pin_sample_t;

    function automatic sense_mode_e decode_mode(input logic [MODE_W-1:0] code);
        sense_mode_e m;
        case (code)
            3'd1:    m = SENSE_BOTH;
            3'd2:    m = SENSE_RISE;
            3'd3:    m = SENSE_FALL;
            3'd5:    m = SENSE_LOW;
            default: m = SENSE_OFF;
        endcase
        return m;
    endfunction

    function automatic logic sense_fire(input sense_mode_e m, input pin_sample_t s);
        logic f;
        case (m)
            SENSE_BOTH: f = s.armed & (s.cur ^ s.prev);
            SENSE_RISE: f = s.armed & s.cur & ~s.prev;
            SENSE_FALL: f = s.armed & ~s.cur & s.prev;
            SENSE_LOW:  f = ~s.cur;
            default:    f = 1'b0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/sense_history.sv
module sense_history #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_level,
    output logic [NUM_PINS-1:0] prev_q,
    output logic                armed_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            prev_q  <= pin_level;
            armed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pin_sense_cell.sv
module pin_sense_cell
    import pin_sense_pkg::*;
#(
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              cur,
    input  logic              prev,
    input  logic              armed,
    output logic              evt
);
    sense_mode_e mode;
    pin_sample_t smp;
    logic        ctrl_unused;

    assign ctrl_unused = ^ctrl[CTRL_W-1:MODE_W];
    assign mode        = decode_mode(ctrl[MODE_W-1:0]);
    assign smp         = '{cur: cur, prev: prev, armed: armed};
    assign evt         = sense_fire(mode, smp);

    // R12: no edge-mode event before the history holds a real sample
    assert_no_first_edge_R12: assert property (@(posedge clk) disable iff (rst)
        (!armed && mode != SENSE_LOW) |-> !evt);

    // R2 / R7: off or reserved codes stay silent
    assert_off_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl[MODE_W-1:0] == 3'd0 || ctrl[MODE_W-1:0] == 3'd4 ||
         ctrl[MODE_W-1:0] >= 3'd6) |-> !evt);

    // R4: rising events only on a real 0-to-1 change
    assert_rise_edge_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl[MODE_W-1:0] == 3'd2 && evt) |-> (cur && !prev));
endmodule

// File: rtl/sense_flag_reg.sv
module sense_flag_reg #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] evt,
    input  logic                clr_valid,
    input  logic [NUM_PINS-1:0] clr_mask,
    output logic [NUM_PINS-1:0] flags_q,
    output logic                irq
);
    logic [NUM_PINS-1:0] clr_eff;
    logic [NUM_PINS-1:0] flags_d;

    assign clr_eff = clr_valid ? clr_mask : '0;
    assign flags_d = (flags_q & ~clr_eff) | evt;
    assign irq     = |flags_q;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    // R8 / R10: every event of the previous cycle is present now
    assert_event_sets_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags_q & $past(evt)) == $past(evt)));

    // R9: without a clear strobe no flag falls
    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !clr_valid |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R11: request falls only through a clear
    assert_irq_fall_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(clr_valid));
endmodule

// File: rtl/pin_irq_sense.sv
module pin_irq_sense
    import pin_sense_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int CTRL_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_PINS-1:0]        pin_level,
    input  logic [NUM_PINS*CTRL_W-1:0] pin_ctrl,
    input  logic                       clr_valid,
    input  logic [NUM_PINS-1:0]        clr_mask,
    output logic [NUM_PINS-1:0]        flags,
    output logic                       irq
);
    logic [NUM_PINS-1:0] prev_q;
    logic                armed_q;
    logic [NUM_PINS-1:0] evt;

    sense_history #(.NUM_PINS(NUM_PINS)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .pin_level (pin_level),
        .prev_q    (prev_q),
        .armed_q   (armed_q)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pin_sense_cell #(.CTRL_W(CTRL_W)) u_cell (
            .clk   (clk),
            .rst   (rst),
            .ctrl  (pin_ctrl[i*CTRL_W +: CTRL_W]),
            .cur   (pin_level[i]),
            .prev  (prev_q[i]),
            .armed (armed_q),
            .evt   (evt[i])
        );
    end

    sense_flag_reg #(.NUM_PINS(NUM_PINS)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .clr_valid (clr_valid),
        .clr_mask  (clr_mask),
        .flags_q   (flags),
        .irq       (irq)
    );

    // R1: clean state right after reset
    assert_reset_clean_R1: assert property (@(posedge clk)
        rst |=> (flags == '0 && !irq));
endmodule

// File: tb/test_pin_irq_sense.sv
module test_pin_irq_sense;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pin_level = 8'h08;
    logic [63:0] pin_ctrl;
    logic        clr_valid = 1'b0;
    logic [7:0]  clr_mask = 8'h00;
    logic [7:0]  flags;
    logic        irq;

    logic [7:0] ctrl_b [8];
    int checks = 0;
    int errors = 0;

    logic [7:0] m_prev  = 8'h00;
    bit         m_armed = 1'b0;
    logic [7:0] m_flags = 8'h00;

    always #2.5 clk = ~clk;

    always_comb
        for (int i = 0; i < 8; i++) pin_ctrl[i*8 +: 8] = ctrl_b[i];

    pin_irq_sense i_pin_irq_sense (
        .clk(clk), .rst(rst), .pin_level(pin_level), .pin_ctrl(pin_ctrl),
        .clr_valid(clr_valid), .clr_mask(clr_mask), .flags(flags), .irq(irq)
    );

    function automatic bit model_fire(input int code, input bit c, input bit p, input bit a);
        if (code == 1) return a && (c != p);
        if (code == 2) return a && c && !p;
        if (code == 3) return a && !c && p;
        if (code == 5) return !c;
        return 1'b0;
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (flags !== m_flags) begin
            errors++;
            $display("FAIL %s flags: actual %h expected %h", tag, flags, m_flags);
        end
        checks++;
        if (irq !== (m_flags != 0)) begin
            errors++;
            $display("FAIL %s irq (R11): actual %b expected %b", tag, irq, m_flags != 0);
        end
    endtask

    task automatic step(input logic [7:0] pins, input bit cv, input logic [7:0] cm,
                        input string tag);
        logic [7:0] ev;
        @(negedge clk);
        pin_level = pins;
        clr_valid = cv;
        clr_mask  = cm;
        ev = 8'h00;
        for (int i = 0; i < 8; i++)
            ev[i] = model_fire(int'(ctrl_b[i][2:0]), pins[i], m_prev[i], m_armed);
        m_flags = (m_flags & ~(cv ? cm : 8'h00)) | ev;
        m_prev  = pins;
        m_armed = 1'b1;
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    initial begin : watchdog
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [7:0] lfsr;
        ctrl_b[0] = 8'h01;  // any change
        ctrl_b[1] = 8'h02;  // rising
        ctrl_b[2] = 8'h03;  // falling
        ctrl_b[3] = 8'h05;  // low level
        ctrl_b[4] = 8'h00;  // off
        ctrl_b[5] = 8'h04;  // reserved
        ctrl_b[6] = 8'hFA;  // rising, upper bits set
        ctrl_b[7] = 8'h07;  // reserved
        pin_level = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        compare("R1 reset");
        @(negedge clk);
        rst = 1'b0;
        // first edge after reset: inputs high, edge modes must stay quiet
        @(posedge clk);
        #1;
        m_prev = 8'hFF; m_armed = 1'b1;
        compare("R12 first edge");

        step(8'hFF, 0, 8'h00, "R12 steady");
        step(8'hFE, 0, 8'h00, "R3 any-change fall");
        step(8'hFF, 1, 8'h01, "R3 R9 clear then change");
        step(8'hFD, 1, 8'h01, "R9 clear pin0");
        step(8'hFF, 0, 8'h00, "R4 rising pin1");
        step(8'hFB, 1, 8'h02, "R5 falling pin2");
        step(8'hFF, 0, 8'h00, "R5 rise ignored pin2");
        step(8'h0F, 1, 8'hFF, "R2 R7 off and reserved silent");
        step(8'hFF, 0, 8'h00, "R7 upper bits ignored rise pin6");
        step(8'hF7, 1, 8'hFF, "R6 low level set");
        step(8'hF7, 1, 8'h08, "R6 R10 clear while low");
        step(8'hF7, 0, 8'h08, "R9 mask ignored without strobe");
        step(8'hFF, 1, 8'h08, "R6 release then clear");
        step(8'h00, 0, 8'h00, "R8 several pins same edge");
        step(8'hFF, 1, 8'hF7, "R10 clear vs rising");
        step(8'hFF, 1, 8'h02, "R11 partial clear");
        step(8'hFF, 1, 8'hFF, "R11 full clear");
        step(8'hFF, 0, 8'h00, "R11 idle low");

        lfsr = 8'h5A;
        for (int n = 0; n < 300; n++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr ^ 8'h08, (n % 3) == 0, {lfsr[3:0], lfsr[7:4]}, "R8 R9 R10 sweep");
        end

        @(negedge clk);
        rst = 1'b1;
        m_flags = 8'h00; m_armed = 1'b0; m_prev = 8'h00;
        @(posedge clk);
        #1;
        compare("R1 second reset");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule